// File: doc/BRIEF.md
# Decimal Adjust Flag Unit

This unit applies the four packed-BCD and unpacked-BCD adjust operations that follow an 8-bit addition or subtraction. It takes a 16-bit accumulator (high byte and low byte), a 16-bit flags word and a 2-bit operation code. It returns the corrected accumulator and the updated flags word. The unit reads the carry and auxiliary-carry inputs from the incoming flags word. Flag bits that an operation does not own pass through unchanged.

A request is accepted on any rising edge where `req_i` is high. The result is registered and appears on the following cycle, with `done_o` high for that cycle. A small two-state sequencer controls the timing. `ST_WAIT` is the idle state. The *accept* transition moves it to `ST_EMIT` when a request is seen. In `ST_EMIT`, the *repeat* transition keeps it in `ST_EMIT` when a new request arrives in the same cycle. Otherwise the *release* transition returns it to `ST_WAIT`. Between requests the result registers hold their last value.

Flag layout: CF is bit 0, PF is bit 2, AF is bit 4, ZF is bit 6 and SF is bit 7. Operation codes: 2'b00 is unpacked add-adjust, 2'b01 is unpacked subtract-adjust, 2'b10 is packed add-adjust and 2'b11 is packed subtract-adjust.

Top module: `dadj_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request, `done_o` is 0, `ax_o` is 0x0000 and `flags_o` is 0x0000.
- R2: A request sampled on one rising edge shows its result and `done_o`=1 after that edge. In any cycle that follows an edge without a request, `done_o` is 0 and `ax_o`/`flags_o` keep their values. Back-to-back requests give back-to-back results.
- R3: Unpacked add-adjust (op 2'b00) corrects when the low nibble of the low byte exceeds 9 or AF (bit 4) is set. The correction adds 6 to the low byte, keeps only its low nibble, increments the high byte, and sets AF and CF. Examples: 0x000A gives 0x0100, and 0x0000 with AF gives 0x0106.
- R4: For op 2'b00 and op 2'b01 with no correction, the accumulator is unchanged and both AF (bit 4) and CF (bit 0) are cleared, even if CF was set on entry.
- R5: Unpacked subtract-adjust (op 2'b01) corrects under the same condition as R3. The correction subtracts 6 from the low byte, keeps its low nibble, decrements the high byte, and sets AF and CF. Examples: 0x000A gives 0xFF04, and 0x0000 with AF gives 0xFF0A.
- R6: Packed add-adjust (op 2'b10) adds 6 and sets AF when the low nibble exceeds 9 or AF is set, and otherwise clears AF. It adds 0x60 and sets CF when the original low byte exceeds 0x99 or CF is set, and otherwise clears CF. Example: 0x9A gives 0x00 with CF and AF set.
- R7: Packed subtract-adjust (op 2'b11) first handles the low digit: under the R6 condition it subtracts 6, sets AF and sets CF if the step borrows, and otherwise clears AF and keeps the incoming CF. It then subtracts 0x60 and sets CF when the original low byte exceeds 0x99 or the CF from the first step is set. Example: 0x00 with AF gives 0x9A with CF and AF set.
- R8: Op 2'b11 sets SF (bit 7) from bit 7 of the resulting low byte. It sets ZF (bit 6) when that byte is zero. It sets PF (bit 2) when that byte has an even number of ones.
- R9: Ops 2'b00, 2'b01 and 2'b10 leave SF, ZF and PF as they were on entry. A zero result does not set ZF.
- R10: Ops 2'b10 and 2'b11 leave the high byte of the accumulator unchanged.
- R11: Flag bits other than bits 0, 2, 4, 6 and 7 pass through unchanged for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, sampled each rising edge |
| op_i | input | 2 | Operation code |
| ax_i | input | 16 | Accumulator in, high byte in [15:8] |
| flags_i | input | 16 | Flags word in |
| done_o | output | 1 | High for one cycle per accepted request |
| ax_o | output | 16 | Adjusted accumulator |
| flags_o | output | 16 | Updated flags word |

## Verification
Both the wrong-sequencer-state case and the datapath-fault case are visible at the ports in the first cycle after the triggering edge. If the sequencer is stuck in or falsely enters `ST_EMIT`, `done_o` is high in a cycle that follows no request. If the result registers are loaded outside a request, the held values change. A fault in a correction path shows up in that same single result cycle. It appears as a wrong low byte, a high byte that moves when it must not, or a mismatch between CF and AF on an unpacked operation. The directed cases target the boundaries between correcting and non-correcting: nibble 9 against 0xA, 0x99 against 0x9A, and the borrow that feeds the second step of packed subtraction.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
    localparam logic [BYTE_W-1:0] LOW_STEP  = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HIGH_STEP = LOW_STEP << NIB_W;
    localparam logic [BYTE_W-1:0] PAIR_MAX  = {DIGIT_MAX, DIGIT_MAX};

    typedef enum logic [1:0] {
        OP_AAA = 2'b00,
        OP_AAS = 2'b01,
        OP_DAA = 2'b10,
        OP_DAS = 2'b11
    } adj_op_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;

    function automatic logic even_ones(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction
endpackage

// File: rtl/dadj_ascii_core.sv
module dadj_ascii_core
    import dadj_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              af_i,
    input  logic              sub_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              fix_o
);
    logic [BYTE_W-1:0] stepped;

    always_comb begin
        fix_o   = (lo_i[NIB_W-1:0] > DIGIT_MAX) | af_i;
        stepped = sub_i ? (lo_i - LOW_STEP) : (lo_i + LOW_STEP);
        if (fix_o) begin
            lo_o = {{(BYTE_W-NIB_W){1'b0}}, stepped[NIB_W-1:0]};
            hi_o = sub_i ? (hi_i - BYTE_W'(1)) : (hi_i + BYTE_W'(1));
        end else begin
            lo_o = lo_i;
            hi_o = hi_i;
        end
    end
endmodule

// File: rtl/dadj_decimal_core.sv
module dadj_decimal_core
    import dadj_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              af_i,
    input  logic              cf_i,
    input  logic              sub_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic              af_o,
    output logic              cf_o
);
    logic [BYTE_W:0]   first;
    logic              lo_fix;
    logic              hi_fix;
    logic              cf_mid;
    logic [BYTE_W-1:0] mid;

    always_comb begin
        lo_fix = (lo_i[NIB_W-1:0] > DIGIT_MAX) | af_i;
        first  = sub_i ? ({1'b0, lo_i} - {1'b0, LOW_STEP})
                       : ({1'b0, lo_i} + {1'b0, LOW_STEP});
        mid    = lo_fix ? first[BYTE_W-1:0] : lo_i;
        cf_mid = cf_i | (lo_fix & first[BYTE_W]);
        hi_fix = (lo_i > PAIR_MAX) | cf_mid;
        if (hi_fix) begin
            lo_o = sub_i ? (mid - HIGH_STEP) : (mid + HIGH_STEP);
        end else begin
            lo_o = mid;
        end
        af_o = lo_fix;
        cf_o = hi_fix;
    end
endmodule

// File: rtl/dadj_flag_merge.sv
module dadj_flag_merge
    import dadj_pkg::*;
#(
    parameter int FLAGS_W = 16,
    parameter int CF_BIT  = 0,
    parameter int PF_BIT  = 2,
    parameter int AF_BIT  = 4,
    parameter int ZF_BIT  = 6,
    parameter int SF_BIT  = 7
) (
    input  logic [FLAGS_W-1:0] flags_i,
    input  logic               result_flags_i,
    input  logic [BYTE_W-1:0]  lo_i,
    input  logic               af_i,
    input  logic               cf_i,
    output logic [FLAGS_W-1:0] flags_o
);
    logic [FLAGS_W-1:0] computed;

    always_comb begin
        computed         = '0;
        computed[CF_BIT] = cf_i;
        computed[AF_BIT] = af_i;
        computed[SF_BIT] = lo_i[BYTE_W-1];
        computed[ZF_BIT] = (lo_i == '0);
        computed[PF_BIT] = even_ones(lo_i);
    end

    for (genvar b = 0; b < FLAGS_W; b++) begin : g_bit
        if (b == CF_BIT || b == AF_BIT) begin : g_carry
            assign flags_o[b] = computed[b];
        end else if (b == SF_BIT || b == ZF_BIT || b == PF_BIT) begin : g_result
            assign flags_o[b] = result_flags_i ? computed[b] : flags_i[b];
        end else begin : g_pass
            assign flags_o[b] = flags_i[b];
        end
    end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
#(
    parameter int FLAGS_W = 16,
    parameter int CF_BIT  = 0,
    parameter int PF_BIT  = 2,
    parameter int AF_BIT  = 4,
    parameter int ZF_BIT  = 6,
    parameter int SF_BIT  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [1:0]         op_i,
    input  logic [WORD_W-1:0]  ax_i,
    input  logic [FLAGS_W-1:0] flags_i,
    output logic               done_o,
    output logic [WORD_W-1:0]  ax_o,
    output logic [FLAGS_W-1:0] flags_o
);
    localparam logic [FLAGS_W-1:0] OWNED_MASK =
        (FLAGS_W'(1) << CF_BIT) | (FLAGS_W'(1) << AF_BIT) |
        (FLAGS_W'(1) << PF_BIT) | (FLAGS_W'(1) << ZF_BIT) |
        (FLAGS_W'(1) << SF_BIT);
    localparam logic [FLAGS_W-1:0] RESULT_MASK =
        (FLAGS_W'(1) << PF_BIT) | (FLAGS_W'(1) << ZF_BIT) |
        (FLAGS_W'(1) << SF_BIT);

    seq_state_e state_q, state_d;
    adj_op_e    op;
    logic [BYTE_W-1:0] lo_in, hi_in;
    logic [BYTE_W-1:0] a_lo, a_hi, d_lo;
    logic a_fix, d_af, d_cf;
    logic [WORD_W-1:0]  ax_next;
    logic [FLAGS_W-1:0] flags_next;
    logic new_af, new_cf;

    assign op    = adj_op_e'(op_i);
    assign lo_in = ax_i[BYTE_W-1:0];
    assign hi_in = ax_i[WORD_W-1:BYTE_W];

    dadj_ascii_core u_ascii (
        .lo_i  (lo_in),
        .hi_i  (hi_in),
        .af_i  (flags_i[AF_BIT]),
        .sub_i (op_i[0]),
        .lo_o  (a_lo),
        .hi_o  (a_hi),
        .fix_o (a_fix)
    );

    dadj_decimal_core u_decimal (
        .lo_i  (lo_in),
        .af_i  (flags_i[AF_BIT]),
        .cf_i  (flags_i[CF_BIT]),
        .sub_i (op_i[0]),
        .lo_o  (d_lo),
        .af_o  (d_af),
        .cf_o  (d_cf)
    );

    always_comb begin
        unique case (op)
            OP_AAA, OP_AAS: begin
                ax_next = {a_hi, a_lo};
                new_af  = a_fix;
                new_cf  = a_fix;
            end
            OP_DAA, OP_DAS: begin
                ax_next = {hi_in, d_lo};
                new_af  = d_af;
                new_cf  = d_cf;
            end
            default: begin
                ax_next = ax_i;
                new_af  = 1'b0;
                new_cf  = 1'b0;
            end
        endcase
    end

    dadj_flag_merge #(
        .FLAGS_W (FLAGS_W),
        .CF_BIT  (CF_BIT),
        .PF_BIT  (PF_BIT),
        .AF_BIT  (AF_BIT),
        .ZF_BIT  (ZF_BIT),
        .SF_BIT  (SF_BIT)
    ) u_merge (
        .flags_i        (flags_i),
        .result_flags_i (op == OP_DAS),
        .lo_i           (ax_next[BYTE_W-1:0]),
        .af_i           (new_af),
        .cf_i           (new_cf),
        .flags_o        (flags_next)
    );

    // Sequencer: accept, repeat and release transitions
    always_comb begin
        unique case (state_q)
            ST_WAIT: state_d = req_i ? ST_EMIT : ST_WAIT;
            ST_EMIT: state_d = req_i ? ST_EMIT : ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ax_o    <= '0;
            flags_o <= '0;
        end else if (req_i) begin
            ax_o    <= ax_next;
            flags_o <= flags_next;
        end
    end

    assign done_o = (state_q == ST_EMIT);

    a_r2_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(req_i));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> ($stable(ax_o) && $stable(flags_o) && !done_o));

    a_r4_carry_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(op_i[1])) |-> (flags_o[CF_BIT] == flags_o[AF_BIT]));

    a_r9_result_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(op_i) != OP_DAS)) |->
        ((flags_o & RESULT_MASK) == ($past(flags_i) & RESULT_MASK)));

    a_r10_high_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(op_i[1])) |->
        (ax_o[WORD_W-1:BYTE_W] == $past(ax_i[WORD_W-1:BYTE_W])));

    a_r11_other_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (((flags_o ^ $past(flags_i)) & ~OWNED_MASK) == '0));
endmodule

// File: tb/test_dadj_unit.sv
module test_dadj_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [15:0] ax_i = '0;
    logic [15:0] flags_i = '0;
    logic        done_o;
    logic [15:0] ax_o;
    logic [15:0] flags_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    localparam logic [1:0] K_AAA = 2'b00, K_AAS = 2'b01, K_DAA = 2'b10, K_DAS = 2'b11;
    localparam logic [15:0] F_CF = 16'h0001, F_PF = 16'h0004, F_AF = 16'h0010,
                            F_ZF = 16'h0040, F_SF = 16'h0080;

    always #4 clk = ~clk;

    dadj_unit i_dadj_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
        .ax_i(ax_i), .flags_i(flags_i),
        .done_o(done_o), .ax_o(ax_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [1:0] op, input logic [15:0] ax,
                         input logic [15:0] fl, input logic [15:0] exp_ax,
                         input logic [15:0] exp_fl);
        @(negedge clk);
        req_i = 1'b1; op_i = op; ax_i = ax; flags_i = fl;
        @(negedge clk);
        req_i = 1'b0; ax_i = 16'hA5A5; flags_i = 16'h5A5A;
        check({tag, " R2 done"}, 16'(done_o), 16'h1);
        check({tag, " ax"}, ax_o, exp_ax);
        check({tag, " flags"}, flags_o, exp_fl);
        @(negedge clk);
        check({tag, " R2 idle done"}, 16'(done_o), 16'h0);
        check({tag, " R2 hold ax"}, ax_o, exp_ax);
        check({tag, " R2 hold flags"}, flags_o, exp_fl);
    endtask

    task automatic t_reset();
        check("R1 done in reset", 16'(done_o), 16'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", 16'(done_o), 16'h0);
        check("R1 ax", ax_o, 16'h0000);
        check("R1 flags", flags_o, 16'h0000);
    endtask

    task automatic t_aaa();
        apply("R3 aaa 0x0A", K_AAA, 16'h000A, 16'h0000, 16'h0100, F_AF | F_CF);
        apply("R3 aaa af", K_AAA, 16'h0000, F_AF, 16'h0106, F_AF | F_CF);
        apply("R4 aaa zero", K_AAA, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        apply("R4 aaa cf cleared", K_AAA, 16'h0000, F_CF, 16'h0000, 16'h0000);
        apply("R4 aaa nine", K_AAA, 16'h0009, 16'h0000, 16'h0009, 16'h0000);
        apply("R9 aaa szp kept", K_AAA, 16'h000A, F_SF | F_ZF | F_PF, 16'h0100,
              F_SF | F_ZF | F_PF | F_AF | F_CF);
        apply("R11 aaa other bits", K_AAA, 16'h0000, 16'hF200 | F_AF, 16'h0106, 16'hF211);
    endtask

    task automatic t_aas();
        apply("R5 aas 0x0A", K_AAS, 16'h000A, 16'h0000, 16'hFF04, F_AF | F_CF);
        apply("R5 aas af", K_AAS, 16'h0000, F_AF, 16'hFF0A, F_AF | F_CF);
        apply("R5 aas high byte", K_AAS, 16'h350A, 16'h0000, 16'h3404, F_AF | F_CF);
        apply("R4 aas zero", K_AAS, 16'h0000, F_CF, 16'h0000, 16'h0000);
    endtask

    task automatic t_daa();
        apply("R6 daa zero", K_DAA, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        apply("R6 daa af", K_DAA, 16'h0000, F_AF, 16'h0006, F_AF);
        apply("R6 daa 0x0A af", K_DAA, 16'h000A, F_AF, 16'h0010, F_AF);
        apply("R6 daa cf", K_DAA, 16'h0000, F_CF, 16'h0060, F_CF);
        apply("R9 daa 0x9A no zf", K_DAA, 16'h009A, 16'h0000, 16'h0000, F_CF | F_AF);
        apply("R10 daa high byte", K_DAA, 16'h5A9A, 16'h0000, 16'h5A00, F_CF | F_AF);
        apply("R9 daa szp kept", K_DAA, 16'h0012, F_SF | F_ZF | F_PF, 16'h0012,
              F_SF | F_ZF | F_PF);
    endtask

    task automatic t_das();
        apply("R8 das zero", K_DAS, 16'h0000, 16'h0000, 16'h0000, F_ZF | F_PF);
        apply("R7 das 0x0A", K_DAS, 16'h000A, 16'h0000, 16'h0004, F_AF);
        apply("R7 das af borrow", K_DAS, 16'h0000, F_AF, 16'h009A,
              F_AF | F_PF | F_SF | F_CF);
        apply("R7 das cf", K_DAS, 16'h0000, F_CF, 16'h00A0, F_CF | F_PF | F_SF);
        apply("R8 das 0xFF", K_DAS, 16'h33FF, F_ZF, 16'h3399, F_AF | F_CF | F_PF | F_SF);
        apply("R10 das high byte", K_DAS, 16'h7700, 16'hF200 | F_SF, 16'h7700,
              16'hF200 | F_ZF | F_PF);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_i = 1'b1; op_i = K_AAA; ax_i = 16'h000A; flags_i = 16'h0000;
        @(negedge clk);
        check("R2 b2b first done", 16'(done_o), 16'h1);
        check("R2 b2b first ax", ax_o, 16'h0100);
        op_i = K_DAS; ax_i = 16'h00FF; flags_i = 16'h0000;
        @(negedge clk);
        req_i = 1'b0;
        check("R2 b2b second done", 16'(done_o), 16'h1);
        check("R2 b2b second ax", ax_o, 16'h0099);
        check("R2 b2b second flags", flags_o, F_AF | F_CF | F_PF | F_SF);
        @(negedge clk);
        check("R2 b2b release", 16'(done_o), 16'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_aaa();
        t_aas();
        t_daa();
        t_das();
        t_back_to_back();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule